// File: doc/BRIEF.md
# Multiplexed Bus Master with Timeout

This block runs read and write transactions for a local requester over a synchronous shared bus. The address and data words travel on one set of wires. A request names the direction, a start address and a word count. A count of one gives a single-word operation. A larger count gives a block operation: the address goes out once, and every later word is marked with a continue opcode. The slave ends each word by raising finish and placing a status code on the operation lines. The master then passes read words back to the requester. It reports one completion status per request.

The three bus groups are the address/data lines, the operation lines and the word-count lines. Each is brought out as a value, an output enable and (where the slave can drive it) an input value. Pad logic combines them outside the block. The master releases the shared lines for one turnaround cycle before read data comes back. A countdown watchdog ends any transaction whose slave stays silent. A try-again status causes the request to be reissued from its address cycle, up to a parameter limit.

Top module: `mux_bus_master`

## Requirements
- R1: Out of reset the block is idle: `req_ready_o`=1, `bus_start_o`=0, both output enables 0, `done_o`=0 and `rd_valid_o`=0.
- R2: An accepted request produces exactly one address cycle. In it `bus_start_o`=1, both enables are 1, `bus_ad_o` carries the request address and `bus_cnt_o` the word count. `bus_op_o` carries the opcode: 1 for a single read, 2 for a single write, 3 for a block read and 4 for a block write.
- R3: In a write, after the address cycle the master drives word k of the request on `bus_ad_o`, with `wr_idx_o`=k, until the slave finishes it. Word 0 leaves the operation lines undriven. Every later word drives `bus_op_o`=5 (continue).
- R4: In a read, the cycle right after the address cycle drives neither the operation lines nor the address/data lines, and the address/data lines stay undriven for the rest of the read. Each word finished with OK appears one cycle later on `rd_data_o`, with its index on `rd_idx_o`, while `rd_valid_o`=1.
- R5: The slave's status on `bus_op_i`, sampled when finish is high, is decoded as 1 = OK, 3 = try again, and any other value = failure. A failure ends the request at once with `done_stat_o`=1.
- R6: A request of N words ends after the N-th word finished with OK. `done_o` is then high for exactly one cycle, with `done_stat_o`=0.
- R7: The watchdog is reloaded with TMO_CYC at each address cycle and at each word finished with OK. If the count reaches zero with no finish, the request ends with `done_stat_o`=2. With default timing, `done_o` rises TMO_CYC+2 cycles after the address cycle, and all bus outputs are released afterwards.
- R8: A try-again status reissues the whole request from a fresh address cycle with the same address. The request may be reissued MAX_RETRY times. A further try-again ends it with `done_stat_o`=3.
- R9: While a request is in progress, `req_ready_o`=0 and `req_valid_i` is ignored. No further address cycle follows the completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Master idle, request taken this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_len_i | input | LENW | Word count (0 treated as 1) |
| req_addr_i | input | W | Start address |
| wr_idx_o | output | LENW | Index of the write word wanted now |
| wr_data_i | input | W | Write word for `wr_idx_o` |
| rd_valid_o | output | 1 | Read word valid |
| rd_idx_o | output | LENW | Index of the read word |
| rd_data_o | output | W | Read word |
| done_o | output | 1 | Request complete (one-cycle pulse) |
| done_stat_o | output | 2 | 0 ok, 1 fail, 2 timeout, 3 retry limit |
| bus_start_o | output | 1 | Start line |
| bus_op_o | output | 3 | Operation code driven by master |
| bus_op_oe_o | output | 1 | Master drives operation lines |
| bus_op_i | input | 3 | Operation lines as seen (slave status) |
| bus_finish_i | input | 1 | Finish line from slave |
| bus_cnt_o | output | LENW | Word count shown in the address cycle |
| bus_ad_o | output | W | Address/data value driven by master |
| bus_ad_oe_o | output | 1 | Master drives address/data lines |
| bus_ad_i | input | W | Address/data lines as seen |

## Verification
Requests are drawn from a table that mixes single and block transfers in both directions. The slave wait states vary, so back-to-back finishes (one word per cycle) are told apart from stalled ones. A read cannot be mistaken for a write by the checks on bus ownership in each phase. Status sequences separate a plain failure from a try-again that later succeeds and from one that runs past the limit. A silent slave pins down the exact watchdog expiry cycle. A request pushed in mid-transaction shows whether the busy master really ignores it.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

  // Master-driven operation codes; slave status shares the same lines.
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_READ  = 3'd1,
    OP_WRITE = 3'd2,
    OP_RBLK  = 3'd3,
    OP_WBLK  = 3'd4,
    OP_CONT  = 3'd5
  } mbm_op_e;

  localparam logic [2:0] SL_OK    = 3'd1;
  localparam logic [2:0] SL_RETRY = 3'd3;

  typedef enum logic [1:0] {
    DS_OK      = 2'd0,
    DS_FAIL    = 2'd1,
    DS_TIMEOUT = 2'd2,
    DS_RLIMIT  = 2'd3
  } mbm_done_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_TURN,
    ST_WDATA,
    ST_RDATA
  } mbm_state_e;

  // Opcode chosen for the address cycle.
  function automatic mbm_op_e pick_op(input logic wr, input logic single);
    if (single) return wr ? OP_WRITE : OP_READ;
    return wr ? OP_WBLK : OP_RBLK;
  endfunction

endpackage

// File: rtl/mbm_wdog.sv
module mbm_wdog #(
  parameter int TMO_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  output logic expired
);
  localparam int CW = $clog2(TMO_CYC + 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (load)              cnt_q <= CW'(TMO_CYC);
    else if (tick && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R7: a fresh load leaves at least one cycle before expiry
  a_r7_reload_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    (load && TMO_CYC != 0) |=> !expired);

endmodule

// File: rtl/mbm_retry.sv
module mbm_retry #(
  parameter int MAX_RETRY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic exhausted
);
  localparam int CW = $clog2(MAX_RETRY + 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  assign exhausted = (cnt_q == CW'(MAX_RETRY));

  // R8: the counter never steps past its limit
  a_r8_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    exhausted && !clr |-> !inc);

endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
  import mbm_pkg::*;
#(
  parameter int W         = 16,
  parameter int LENW      = 4,
  parameter int TMO_CYC   = 8,
  parameter int MAX_RETRY = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic            req_write_i,
  input  logic [LENW-1:0] req_len_i,
  input  logic [W-1:0]    req_addr_i,
  output logic [LENW-1:0] wr_idx_o,
  input  logic [W-1:0]    wr_data_i,
  output logic            rd_valid_o,
  output logic [LENW-1:0] rd_idx_o,
  output logic [W-1:0]    rd_data_o,
  output logic            done_o,
  output logic [1:0]      done_stat_o,
  output logic            bus_start_o,
  output logic [2:0]      bus_op_o,
  output logic            bus_op_oe_o,
  input  logic [2:0]      bus_op_i,
  input  logic            bus_finish_i,
  output logic [LENW-1:0] bus_cnt_o,
  output logic [W-1:0]    bus_ad_o,
  output logic            bus_ad_oe_o,
  input  logic [W-1:0]    bus_ad_i
);

  mbm_state_e      state_q, state_d;
  logic            wr_q;
  logic [LENW-1:0] len_q;
  logic [W-1:0]    addr_q;
  logic [LENW-1:0] idx_q;

  // Named internal events
  logic accept, in_data, evt_fin, st_ok, st_retry, st_fail, last_word;
  logic wd_load, wd_tick, wd_expired, evt_tmo;
  logic rt_clr, rt_inc, rt_exhausted;
  logic done_d;
  mbm_done_e stat_d;

  assign accept    = (state_q == ST_IDLE) && req_valid_i;
  assign in_data   = (state_q == ST_WDATA) || (state_q == ST_RDATA);
  assign evt_fin   = in_data && bus_finish_i;
  assign st_ok     = evt_fin && (bus_op_i == SL_OK);
  assign st_retry  = evt_fin && (bus_op_i == SL_RETRY);
  assign st_fail   = evt_fin && !st_ok && !st_retry;
  assign last_word = (idx_q == len_q - 1'b1);

  // Watchdog: reload at each start and each accepted word
  assign wd_load = (state_q == ST_ADDR) || (st_ok && !last_word);
  assign wd_tick = in_data || (state_q == ST_TURN);
  assign evt_tmo = wd_tick && !evt_fin && wd_expired;

  mbm_wdog #(.TMO_CYC(TMO_CYC)) u_wdog (
    .clk(clk), .rst_n(rst_n), .load(wd_load), .tick(wd_tick), .expired(wd_expired)
  );

  assign rt_clr = accept;
  assign rt_inc = st_retry && !rt_exhausted;

  mbm_retry #(.MAX_RETRY(MAX_RETRY)) u_retry (
    .clk(clk), .rst_n(rst_n), .clr(rt_clr), .inc(rt_inc), .exhausted(rt_exhausted)
  );

  // Next state and completion
  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    stat_d  = DS_OK;
    unique case (state_q)
      ST_IDLE:  if (req_valid_i) state_d = ST_ADDR;
      ST_ADDR:  state_d = wr_q ? ST_WDATA : ST_TURN;
      ST_TURN:  begin
        if (evt_tmo) begin
          state_d = ST_IDLE; done_d = 1'b1; stat_d = DS_TIMEOUT;
        end else begin
          state_d = ST_RDATA;
        end
      end
      ST_WDATA, ST_RDATA: begin
        if (st_ok && last_word) begin
          state_d = ST_IDLE; done_d = 1'b1; stat_d = DS_OK;
        end else if (st_fail) begin
          state_d = ST_IDLE; done_d = 1'b1; stat_d = DS_FAIL;
        end else if (st_retry) begin
          if (rt_exhausted) begin
            state_d = ST_IDLE; done_d = 1'b1; stat_d = DS_RLIMIT;
          end else begin
            state_d = ST_ADDR;
          end
        end else if (evt_tmo) begin
          state_d = ST_IDLE; done_d = 1'b1; stat_d = DS_TIMEOUT;
        end
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      wr_q        <= 1'b0;
      len_q       <= '0;
      addr_q      <= '0;
      idx_q       <= '0;
      done_o      <= 1'b0;
      done_stat_o <= DS_OK;
      rd_valid_o  <= 1'b0;
      rd_idx_o    <= '0;
      rd_data_o   <= '0;
    end else begin
      state_q     <= state_d;
      done_o      <= done_d;
      done_stat_o <= stat_d;
      rd_valid_o  <= st_ok && !wr_q;
      if (st_ok) begin
        rd_idx_o  <= idx_q;
        rd_data_o <= bus_ad_i;
      end
      if (accept) begin
        wr_q   <= req_write_i;
        len_q  <= (req_len_i == '0) ? LENW'(1) : req_len_i;
        addr_q <= req_addr_i;
      end
      if (state_q == ST_ADDR)       idx_q <= '0;
      else if (st_ok && !last_word) idx_q <= idx_q + 1'b1;
    end
  end

  // Bus drive, decoded from the registered state
  logic is_addr;
  assign is_addr     = (state_q == ST_ADDR);
  assign req_ready_o = (state_q == ST_IDLE);
  assign bus_start_o = is_addr;
  assign bus_op_oe_o = is_addr || ((state_q == ST_WDATA) && (idx_q != '0));
  assign bus_op_o    = is_addr ? pick_op(wr_q, len_q == LENW'(1)) : OP_CONT;
  assign bus_ad_oe_o = is_addr || (state_q == ST_WDATA);
  assign bus_ad_o    = is_addr ? addr_q : wr_data_i;
  assign bus_cnt_o   = is_addr ? len_q : '0;
  assign wr_idx_o    = idx_q;

  // R2: start lasts one cycle per attempt
  a_r2_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start_o |=> !bus_start_o);

  // R4: a read address cycle is followed by a released bus
  a_r4_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start_o && (bus_op_o == OP_READ || bus_op_o == OP_RBLK))
      |=> (!bus_ad_oe_o && !bus_op_oe_o));

  // R3: a write address cycle is followed by data on the shared lines
  a_r3_write_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start_o && (bus_op_o == OP_WRITE || bus_op_o == OP_WBLK)) |=> bus_ad_oe_o);

  // R5: a failure status ends the request in the next cycle
  a_r5_fail_ends: assert property (@(posedge clk) disable iff (!rst_n)
    st_fail |=> (done_o && done_stat_o == DS_FAIL));

  // R4: read words only follow a slave finish
  a_r4_rd_after_fin: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> $past(evt_fin));

  // R7: a timeout never coincides with a finish
  a_r7_tmo_no_fin: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && done_stat_o == DS_TIMEOUT) |-> $past(!bus_finish_i));

  // R9: a taken request always yields an address cycle next
  a_r9_accept_start: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready_o && req_valid_i) |=> bus_start_o);

  // R6: completion is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: tb/mux_bus_master_tb.sv
module mux_bus_master_tb_top;

  localparam int W = 16;
  localparam int LENW = 4;
  localparam int TMO = 8;
  localparam int MAXR = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic            req_valid = 1'b0;
  logic            req_ready;
  logic            req_write = 1'b0;
  logic [LENW-1:0] req_len = '0;
  logic [W-1:0]    req_addr = '0;
  logic [LENW-1:0] wr_idx;
  logic [W-1:0]    wr_data;
  logic            rd_valid;
  logic [LENW-1:0] rd_idx;
  logic [W-1:0]    rd_data;
  logic            done;
  logic [1:0]      done_stat;
  logic            b_start;
  logic [2:0]      b_op_o;
  logic            b_op_oe;
  logic [2:0]      b_op_i = '0;
  logic            b_fin = 1'b0;
  logic [LENW-1:0] b_cnt;
  logic [W-1:0]    b_ad_o;
  logic            b_ad_oe;
  logic [W-1:0]    b_ad_i = '0;

  mux_bus_master #(.W(W), .LENW(LENW), .TMO_CYC(TMO), .MAX_RETRY(MAXR)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_len_i(req_len), .req_addr_i(req_addr),
    .wr_idx_o(wr_idx), .wr_data_i(wr_data),
    .rd_valid_o(rd_valid), .rd_idx_o(rd_idx), .rd_data_o(rd_data),
    .done_o(done), .done_stat_o(done_stat),
    .bus_start_o(b_start), .bus_op_o(b_op_o), .bus_op_oe_o(b_op_oe),
    .bus_op_i(b_op_i), .bus_finish_i(b_fin), .bus_cnt_o(b_cnt),
    .bus_ad_o(b_ad_o), .bus_ad_oe_o(b_ad_oe), .bus_ad_i(b_ad_i)
  );

  int n_tests = 0;
  int n_fail = 0;
  bit summary_done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rdat(input logic [W-1:0] a, input int i);
    return (a ^ 16'hA5A5) + W'(i);
  endfunction
  function automatic logic [W-1:0] wdat(input logic [W-1:0] a, input int i);
    return (a ^ 16'h3C3C) + W'(i * 16);
  endfunction

  // Current request as seen by the slave model
  logic            cur_wr = 1'b0;
  logic [W-1:0]    cur_addr = '0;
  int              cur_len = 1;
  int              cfg_delay = 0;
  int              cfg_nbad = 0;
  logic [2:0]      cfg_bad = 3'd0;
  bit              cfg_silent = 0;
  int              n_start = 0, n_wr = 0, n_rd = 0, n_bad_done = 0;

  assign wr_data = wdat(cur_addr, int'(wr_idx));

  function automatic int exp_op();
    if (cur_len == 1) return cur_wr ? 2 : 1;
    return cur_wr ? 4 : 3;
  endfunction

  // Slave model: reacts at the falling edge, away from the sample edge
  task automatic slave_loop();
    bit s_act = 0, s_turn = 0;
    int sidx = 0, swait = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        s_act = 0; b_fin = 1'b0; b_op_i = '0;
        continue;
      end
      if (rd_valid) begin
        n_rd++;
        chk("R4 read word", int'(rd_data), int'(rdat(cur_addr, int'(rd_idx))));
      end
      b_fin = 1'b0; b_op_i = '0;
      if (b_start) begin
        n_start++;
        chk("R2 opcode", int'(b_op_o), exp_op());
        chk("R2/R8 address", int'(b_ad_o), int'(cur_addr));
        chk("R2 count", int'(b_cnt), cur_len);
        chk("R2 enables", int'({b_op_oe, b_ad_oe}), 3);
        s_act = 1; s_turn = !cur_wr; sidx = 0; swait = cfg_delay;
      end else if (s_act && !cfg_silent) begin
        if (s_turn) begin
          chk("R4 turnaround release", int'({b_op_oe, b_ad_oe}), 0);
          s_turn = 0;
        end else begin
          if (!cur_wr) chk("R4 read lines free", int'(b_ad_oe), 0);
          else begin
            chk("R3 data driven", int'(b_ad_oe), 1);
            chk("R3 op lines", int'({b_op_oe, b_op_o}), (sidx == 0) ? int'(b_op_o) : 13);
          end
          if (swait > 0) swait--;
          else begin
            b_fin = 1'b1;
            if (n_bad_done < cfg_nbad) begin
              b_op_i = cfg_bad; n_bad_done++; s_act = 0;
            end else begin
              b_op_i = 3'd1;
              if (cur_wr) begin
                chk("R3 write word", int'(b_ad_o), int'(wdat(cur_addr, sidx)));
                chk("R3 write index", int'(wr_idx), sidx);
                n_wr++;
              end else begin
                b_ad_i = rdat(cur_addr, sidx);
              end
              if (sidx == cur_len - 1) s_act = 0;
              else begin sidx++; swait = cfg_delay; end
            end
          end
        end
      end
    end
  endtask

  initial slave_loop();

  task automatic issue(input logic wr, input int len, input logic [W-1:0] a);
    cur_wr = wr; cur_addr = a; cur_len = len;
    n_start = 0; n_wr = 0; n_rd = 0; n_bad_done = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_len = LENW'(len); req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  // Vector table: write, len, addr, delay, bad count, bad code, expected status
  localparam int NV = 8;
  localparam bit V_WR   [NV] = '{0, 1, 0, 1, 1, 0, 1, 0};
  localparam int V_LEN  [NV] = '{1, 1, 4, 4, 3, 2, 2, 1};
  localparam int V_ADDR [NV] = '{'h0100, 'h0200, 'h0300, 'h0400, 'h0500, 'h0600, 'h0700, 'h0800};
  localparam int V_DLY  [NV] = '{0, 2, 1, 0, 1, 0, 0, 3};
  localparam int V_NBAD [NV] = '{0, 0, 0, 0, 1, 2, 3, 1};
  localparam int V_BAD  [NV] = '{0, 0, 0, 0, 2, 3, 3, 6};
  localparam int V_STAT [NV] = '{0, 0, 0, 0, 1, 0, 3, 1};

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ready", int'(req_ready), 1);
    chk("R1 bus idle", int'({b_start, b_op_oe, b_ad_oe}), 0);
    chk("R1 outputs quiet", int'({done, rd_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", int'({req_ready, b_start}), 2);

    for (int i = 0; i < NV; i++) begin
      cfg_delay = V_DLY[i]; cfg_nbad = V_NBAD[i]; cfg_bad = 3'(V_BAD[i]); cfg_silent = 0;
      issue(V_WR[i], V_LEN[i], W'(V_ADDR[i]));
      wait_done(cyc);
      chk($sformatf("R5/R6/R8 status v%0d", i), int'(done_stat), V_STAT[i]);
      chk($sformatf("R6 done seen v%0d", i), int'(done), 1);
      @(negedge clk);
      chk($sformatf("R6 done pulse v%0d", i), int'(done), 0);
      chk($sformatf("R8 attempts v%0d", i), n_start,
          (V_BAD[i] == 3) ? ((V_NBAD[i] > MAXR) ? MAXR + 1 : V_NBAD[i] + 1) : 1);
      chk($sformatf("R6 words v%0d", i), V_WR[i] ? n_wr : n_rd,
          (V_STAT[i] == 0) ? V_LEN[i] : 0);
      repeat (2) @(negedge clk);
    end

    // R7: silent slave on a write and on a read
    for (int k = 0; k < 2; k++) begin
      cfg_delay = 0; cfg_nbad = 0; cfg_silent = 1;
      issue(k == 0, 2, W'(16'h0900 + k));
      wait_done(cyc);
      chk("R7 timeout status", int'(done_stat), 2);
      chk("R7 expiry cycle", cyc, TMO + 2);
      @(negedge clk);
      chk("R7 bus released", int'({b_start, b_op_oe, b_ad_oe}), 0);
    end
    cfg_silent = 0;

    // R9: request offered while busy is ignored
    cfg_delay = 3; cfg_nbad = 0;
    issue(1'b1, 1, 16'h0A00);
    chk("R9 busy not ready", int'(req_ready), 0);
    req_valid = 1'b1; req_addr = 16'h0B00; req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(cyc);
    chk("R9 first request ok", int'(done_stat), 0);
    repeat (5) @(negedge clk);
    chk("R9 no extra start", n_start, 1);
    chk("R9 idle again", int'(req_ready), 1);

    if (!summary_done) begin
      summary_done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    end
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    if (!summary_done) begin
      summary_done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    end
    $finish;
  end

endmodule